// File: doc/BRIEF.md
# Single-Entry Store Buffer with Load Forwarding

This block sits between a load/store pipeline and a single-ported data array. Each store is latched into a one-entry holding register in the cycle it is issued, while the cache tag lookup for it runs. The tag result arrives one cycle later. A store that hits is written into the array in the first cycle in which no load needs the port. A store that misses is dropped and reported to the miss handler. Stores can be issued every cycle without a stall.

A load never waits. If it targets the same aligned doubleword as a store that hits and is still waiting, it gets a per-byte merge of the array contents and the waiting store bytes. In that same access the port also writes the waiting bytes into the array. The array must therefore allow one read plus a byte-masked write of the same row in one access, with the read returning the contents from before the write. A flush request is acknowledged once the holding register is empty.

Top module: `stbuf_fwd`

## Requirements
- R1: After reset the holding register is empty: no array write, no miss report, and a raised flush_req is acknowledged in the same cycle.
- R2: A store request is captured in its issue cycle. The tag_hit input belonging to it is sampled in the following cycle, the lookup cycle. In other cycles tag_hit has no effect.
- R3: A store that hits is written to the array (arr_en=1, arr_we=1, its index and byte enables) in the first cycle from its lookup cycle onward in which no load is presented, or earlier through R5.
- R4: Back-to-back stores never stall. A waiting entry is written to the array in the cycle a new store arrives, and the new store takes its place.
- R5: A load whose aligned index equals that of a waiting hit store returns the array bytes with each byte whose store enable bit b is set replaced by store byte b (bits 8b+7:8b). In that same cycle the store is written (arr_we=1) and the holding register is freed.
- R6: A load to a different index only reads the array (arr_we=0) and leaves the waiting store in place.
- R7: A store whose tag_hit is 0 raises miss_valid for one cycle in its lookup cycle, with miss_idx set to its aligned index. It is never written to the array and is never forwarded.
- R8: A load is served in its own cycle: ld_valid=1, arr_en=1 and arr_idx equal to the load's aligned index, with no stall.
- R9: flush_ack is 1 exactly when flush_req is 1 and the holding register is empty. The requester issues no requests while flushing, so a waiting entry drains within one cycle.
- R10: Addresses match on the aligned index req_addr[31:3]. The byte-offset bits [2:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pipeline request present |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 64 | Store data |
| req_be | input | 8 | Store byte enables |
| tag_hit | input | 1 | Tag result for the store issued in the previous cycle |
| flush_req | input | 1 | Request to empty the holding register |
| flush_ack | output | 1 | Holding register empty while flush_req is high |
| ld_valid | output | 1 | Load data valid this cycle |
| ld_data | output | 64 | Load result after forwarding |
| miss_valid | output | 1 | Looked-up store missed and was dropped |
| miss_idx | output | 29 | Aligned index of the dropped store |
| arr_en | output | 1 | Array access this cycle |
| arr_we | output | 1 | Array write this cycle (may combine with a read) |
| arr_idx | output | 29 | Array row index |
| arr_be | output | 8 | Array write byte enables |
| arr_wdata | output | 64 | Array write data |
| arr_rdata | input | 64 | Array read data (pre-write contents, same cycle) |

## Verification
On every cycle, the assertions check the following: a store always reaches the lookup state, a ready entry drains whenever no load is present, a load is always served at its own index, a miss cycle never writes, and an acknowledged flush never coincides with a write. The per-byte merge results, the exact drain ordering across interleaved loads, and the final array contents after misses can only be shown by the bench. It compares every load result and the array model against an architectural memory image.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;

    localparam int unsigned SB_ADDR_W = 32;
    localparam int unsigned SB_DATA_W = 64;
    localparam int unsigned SB_BYTES  = SB_DATA_W / 8;
    localparam int unsigned SB_OFS_W  = $clog2(SB_BYTES);
    localparam int unsigned SB_IDX_W  = SB_ADDR_W - SB_OFS_W;

    typedef enum logic [1:0] {
        SB_EMPTY  = 2'd0,
        SB_LOOKUP = 2'd1,
        SB_READY  = 2'd2
    } sb_state_e;

    typedef struct packed {
        logic [SB_IDX_W-1:0]  idx;
        logic [SB_DATA_W-1:0] data;
        logic [SB_BYTES-1:0]  be;
    } sb_entry_t;

    function automatic logic [SB_IDX_W-1:0] sb_index(input logic [SB_ADDR_W-1:0] a);
        return a[SB_ADDR_W-1:SB_OFS_W];
    endfunction

endpackage

// File: rtl/sb_entry_reg.sv
module sb_entry_reg
    import stbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  sb_entry_t cap_entry,
    input  logic      release_ent,
    input  logic      tag_hit,
    output sb_state_e state,
    output sb_entry_t entry
);
    sb_state_e state_q;
    sb_entry_t entry_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SB_EMPTY;
            entry_q <= '0;
        end else if (capture) begin
            state_q <= SB_LOOKUP;
            entry_q <= cap_entry;
        end else if (release_ent) begin
            state_q <= SB_EMPTY;
        end else if (state_q == SB_LOOKUP) begin
            state_q <= tag_hit ? SB_READY : SB_EMPTY;
        end
    end

    assign state = state_q;
    assign entry = entry_q;
endmodule

// File: rtl/sb_port_ctrl.sv
module sb_port_ctrl
    import stbuf_pkg::*;
(
    input  sb_state_e            state,
    input  sb_entry_t            entry,
    input  logic                 tag_hit,
    input  logic                 is_load,
    input  logic [SB_IDX_W-1:0]  req_idx,
    output logic                 fwd,
    output logic                 release_ent,
    output logic                 miss,
    output logic                 arr_en,
    output logic                 arr_we,
    output logic [SB_IDX_W-1:0]  arr_idx,
    output logic [SB_BYTES-1:0]  arr_be,
    output logic [SB_DATA_W-1:0] arr_wdata
);
    logic live;
    logic same_row;

    always_comb begin
        live        = (state == SB_READY) || ((state == SB_LOOKUP) && tag_hit);
        same_row    = (entry.idx == req_idx);
        fwd         = is_load && live && same_row;
        release_ent = live && (!is_load || same_row);
        miss        = (state == SB_LOOKUP) && !tag_hit;
        arr_en      = is_load || release_ent;
        arr_we      = release_ent;
        arr_idx     = is_load ? req_idx : entry.idx;
        arr_be      = release_ent ? entry.be : '0;
        arr_wdata   = entry.data;
    end
endmodule

// File: rtl/sb_load_merge.sv
module sb_load_merge
    import stbuf_pkg::*;
(
    input  logic                 fwd,
    input  sb_entry_t            entry,
    input  logic [SB_DATA_W-1:0] rdata,
    output logic [SB_DATA_W-1:0] ld_data
);
    for (genvar b = 0; b < SB_BYTES; b++) begin : g_lane
        assign ld_data[b*8 +: 8] = (fwd && entry.be[b]) ? entry.data[b*8 +: 8]
                                                         : rdata[b*8 +: 8];
    end
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd
    import stbuf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_is_store,
    input  logic [SB_ADDR_W-1:0] req_addr,
    input  logic [SB_DATA_W-1:0] req_wdata,
    input  logic [SB_BYTES-1:0]  req_be,
    input  logic                 tag_hit,
    input  logic                 flush_req,
    output logic                 flush_ack,
    output logic                 ld_valid,
    output logic [SB_DATA_W-1:0] ld_data,
    output logic                 miss_valid,
    output logic [SB_IDX_W-1:0]  miss_idx,
    output logic                 arr_en,
    output logic                 arr_we,
    output logic [SB_IDX_W-1:0]  arr_idx,
    output logic [SB_BYTES-1:0]  arr_be,
    output logic [SB_DATA_W-1:0] arr_wdata,
    input  logic [SB_DATA_W-1:0] arr_rdata
);
    sb_state_e st;
    sb_entry_t ent;
    sb_entry_t cap;
    logic      is_load, is_store, fwd, rel, miss;
    logic [SB_IDX_W-1:0] ridx;

    assign ridx     = sb_index(req_addr);
    assign is_load  = req_valid && !req_is_store;
    assign is_store = req_valid && req_is_store;
    assign cap      = '{idx: ridx, data: req_wdata, be: req_be};

    sb_entry_reg u_ent (
        .clk(clk), .rst(rst), .capture(is_store), .cap_entry(cap),
        .release_ent(rel), .tag_hit(tag_hit), .state(st), .entry(ent)
    );

    sb_port_ctrl u_ctl (
        .state(st), .entry(ent), .tag_hit(tag_hit), .is_load(is_load),
        .req_idx(ridx), .fwd(fwd), .release_ent(rel), .miss(miss),
        .arr_en(arr_en), .arr_we(arr_we), .arr_idx(arr_idx),
        .arr_be(arr_be), .arr_wdata(arr_wdata)
    );

    sb_load_merge u_mrg (
        .fwd(fwd), .entry(ent), .rdata(arr_rdata), .ld_data(ld_data)
    );

    assign ld_valid   = is_load;
    assign miss_valid = miss;
    assign miss_idx   = ent.idx;
    assign flush_ack  = flush_req && (st == SB_EMPTY);
endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import stbuf_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_is_store,
    input logic [SB_ADDR_W-1:0] req_addr,
    input logic                 ld_valid,
    input logic                 miss_valid,
    input logic                 flush_ack,
    input logic                 arr_en,
    input logic                 arr_we,
    input logic [SB_IDX_W-1:0]  arr_idx,
    input sb_state_e            st
);
    AST_STORE_TO_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_store) |=> (st == SB_LOOKUP)); // R2
    AST_READY_DRAINS: assert property (@(posedge clk) disable iff (rst)
        ((st == SB_READY) && !(req_valid && !req_is_store)) |-> (arr_en && arr_we)); // R3
    AST_LOAD_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_store) |-> (ld_valid && arr_en && arr_idx == sb_index(req_addr))); // R8
    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        miss_valid |-> !arr_we); // R7
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        flush_ack |-> !arr_we); // R9
    AST_WRITE_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (st != SB_EMPTY)); // R4
endmodule

bind stbuf_fwd sb_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_addr(req_addr), .ld_valid(ld_valid), .miss_valid(miss_valid),
    .flush_ack(flush_ack), .arr_en(arr_en), .arr_we(arr_we),
    .arr_idx(arr_idx), .st(st)
);

// File: tb/sim_stbuf_fwd.sv
module sim_stbuf_fwd;
    import stbuf_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, req_valid, req_is_store, tag_hit, flush_req;
    logic [SB_ADDR_W-1:0] req_addr;
    logic [SB_DATA_W-1:0] req_wdata, ld_data, arr_wdata, arr_rdata;
    logic [SB_BYTES-1:0]  req_be, arr_be;
    logic flush_ack, ld_valid, miss_valid, arr_en, arr_we;
    logic [SB_IDX_W-1:0] miss_idx, arr_idx;

    stbuf_fwd u0 (.*);

    logic [SB_DATA_W-1:0] mem   [8];
    logic [SB_DATA_W-1:0] ref_m [8];
    assign arr_rdata = mem[arr_idx[2:0]];

    always @(posedge clk)
        if (arr_en && arr_we)
            for (int b = 0; b < SB_BYTES; b++)
                if (arr_be[b]) mem[arr_idx[2:0]][b*8 +: 8] <= arr_wdata[b*8 +: 8];

    int total = 0, bad = 0;
    bit p_v = 0, p_hit = 0;
    logic [2:0] p_idx;
    logic [SB_DATA_W-1:0] p_data;
    logic [SB_BYTES-1:0]  p_be;

    function automatic logic [SB_DATA_W-1:0] merge(input logic [SB_DATA_W-1:0] base,
            input logic [SB_DATA_W-1:0] upd, input logic [SB_BYTES-1:0] be);
        logic [SB_DATA_W-1:0] r = base;
        for (int b = 0; b < SB_BYTES; b++) if (be[b]) r[b*8 +: 8] = upd[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [SB_DATA_W-1:0] act,
                       input logic [SB_DATA_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 idle, 1 load, 2 store; returns at negedge+1 with outputs settled
    task automatic cyc(input int kind, input logic [2:0] idx, input logic [2:0] ofs,
                       input logic [SB_DATA_W-1:0] d, input logic [SB_BYTES-1:0] be,
                       input bit hit);
        @(negedge clk);
        tag_hit = p_v ? p_hit : 1'($urandom);   // R2: ignored outside lookup
        if (p_v && p_hit) ref_m[p_idx] = merge(ref_m[p_idx], p_data, p_be);
        req_valid    = (kind != 0);
        req_is_store = (kind == 2);
        req_addr     = {26'd0, idx, ofs};
        req_wdata    = d;
        req_be       = be;
        #1;
        chk(miss_valid == (p_v && !p_hit), "R7 miss_valid", 64'(miss_valid), 64'(p_v && !p_hit));
        if (p_v && !p_hit) chk(miss_idx == SB_IDX_W'(p_idx), "R7 miss_idx", 64'(miss_idx), 64'(p_idx));
        if (kind == 1) begin
            chk(ld_valid, "R8 ld_valid", 64'(ld_valid), 64'd1);
            chk(ld_data == ref_m[idx], "R5 R10 load data", ld_data, ref_m[idx]);
        end
        p_v = (kind == 2); p_hit = hit; p_idx = idx; p_data = d; p_be = be;
    endtask

    bit done = 0;
    initial begin
        #(100000 * 10);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin
            mem[i]   = {8{8'(i * 17 + 3)}};
            ref_m[i] = mem[i];
        end
        rst = 1; req_valid = 0; req_is_store = 0; req_addr = '0; req_wdata = '0;
        req_be = '0; tag_hit = 0; flush_req = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0; flush_req = 1; #1;
        chk(flush_ack, "R1 flush_ack after reset", 64'(flush_ack), 64'd1);
        chk(!arr_we && !miss_valid, "R1 quiet after reset", 64'({arr_we, miss_valid}), 64'd0);
        flush_req = 0;

        // R3: hit store drains in its lookup cycle when idle
        cyc(2, 3'd5, 3'd0, 64'h1111_2222_3333_4444, 8'hff, 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk(arr_we && arr_idx == 5, "R3 drain in lookup cycle", 64'(arr_idx), 64'd5);

        // R4 + R5 + R10: back-to-back stores then partial-offset load of same row
        cyc(2, 3'd1, 3'd0, 64'hAAAA_AAAA_AAAA_AAAA, 8'hff, 1);
        cyc(2, 3'd1, 3'd4, 64'h0000_0000_BBBB_BBBB, 8'h0f, 1);
        chk(arr_we && arr_idx == 1 && arr_be == 8'hff, "R4 older store written", 64'(arr_be), 64'hff);
        cyc(1, 3'd1, 3'd3, 0, 0, 0);
        chk(arr_we && arr_be == 8'h0f, "R5 combined write", 64'(arr_be), 64'h0f);

        // R6: unrelated loads keep the entry waiting
        cyc(2, 3'd6, 3'd0, 64'h0123_4567_89AB_CDEF, 8'hf0, 1);
        cyc(1, 3'd7, 3'd0, 0, 0, 0);
        chk(!arr_we && arr_idx == 7, "R6 read only", 64'(arr_we), 64'd0);
        cyc(1, 3'd0, 3'd0, 0, 0, 0);
        chk(!arr_we, "R6 still waiting", 64'(arr_we), 64'd0);
        cyc(1, 3'd6, 3'd7, 0, 0, 0);
        chk(arr_we, "R5 merge with waiting entry", 64'(arr_we), 64'd1);

        // R7: miss store then load of same row sees old data
        cyc(2, 3'd2, 3'd0, 64'hDEAD_BEEF_DEAD_BEEF, 8'hff, 0);
        cyc(1, 3'd2, 3'd0, 0, 0, 0);
        chk(!arr_we, "R7 no write on miss", 64'(arr_we), 64'd0);

        // R9: flush waits for drain
        cyc(2, 3'd4, 3'd0, 64'h5555_6666_7777_8888, 8'h3c, 1);
        flush_req = 1;
        cyc(0, 0, 0, 0, 0, 0);
        chk(!flush_ack, "R9 no ack while entry live", 64'(flush_ack), 64'd0);
        cyc(0, 0, 0, 0, 0, 0);
        chk(flush_ack, "R9 ack after drain", 64'(flush_ack), 64'd1);
        flush_req = 0;

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int k = $urandom % 3;
            cyc(k, 3'($urandom % 4), 3'($urandom), {$urandom, $urandom}, 8'($urandom),
                ($urandom % 4) != 0);
        end

        cyc(0, 0, 0, 0, 0, 0);
        flush_req = 1;
        cyc(0, 0, 0, 0, 0, 0);
        chk(flush_ack, "R9 final flush ack", 64'(flush_ack), 64'd1);
        for (int i = 0; i < 8; i++)
            chk(mem[i] == ref_m[i], "R3 R7 array contents", mem[i], ref_m[i]);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule